// File: doc/BRIEF.md
# Coherent Store Buffer Pair

This block gives each of two cores a small in-order store queue in front of a private, direct-mapped, write-back line cache. The caches are kept coherent over one shared snooping bus. A store from a core is parked in its queue and is not part of the cache, so the other core cannot observe it. When it reaches the head of the queue, it writes the cache directly if the line is already owned. Otherwise it first takes ownership with a read-for-ownership bus transaction. That transaction removes the peer's copy and pulls the peer's dirty data if the peer had modified the line.

A fence input per core holds that core, refusing new stores, until its queue has emptied into the cache. Backing memory sits outside the block behind a single-word read/write port. A fixed-priority arbiter orders simultaneous requests from the two cores, so conflicting writes to one line always fall into one total order. A local lookup port per core exposes the state and contents of one cache line so that the surrounding logic can observe coherence state.

Top module: `coherentStoreSys`

## Requirements
- R1: A store held in the queue is not in the cache: immediately after it is accepted, a lookup of its line still reports the previous state (Invalid if the line was not held), and a peer snoop is answered from the cache only.
- R2: A head store whose line is not held Modified or Exclusive does not write the cache. It issues a read-for-ownership, merges its enabled bytes (byte k is data bits 8k+7:8k) into the line fetched from memory, and leaves the line Modified.
- R3: A granted read-for-ownership leaves the peer's copy of that line Invalid (lookup state 0).
- R4: If the peer held the line Modified, its data is written to memory in the grant cycle and is the base into which the requester merges its store.
- R5: A head store that hits a Modified or Exclusive line writes the cache and leaves it Modified, without writing memory.
- R6: While a core's fence is high and its queue is not empty, stall is high and its store-ready is low. Stall drops once the queue has drained.
- R7: At most one core is granted the bus per cycle. When both request in the same cycle, core 0 is granted first and core 1 follows, so both stores to one line survive in that order.
- R8: The queue holds DEPTH stores, lowers store-ready when full, and drains strictly in acceptance order, so the last store to a byte wins.
- R9: A store whose index holds a Modified line of another tag first writes that victim line back to memory and invalidates it, then takes ownership of its own line.
- R10: After reset, every line is Invalid, store-ready is high and stall is low on both cores.
- R11: No line is held Modified or Exclusive by both cores at once.

Lookup state encoding: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified. Index is the low INDEX_W bits of the word address; the tag is the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 2 | Per-core store request |
| stAddr | input | 2 x ADDR_W | Per-core store word address |
| stBe | input | 2 x DATA_W/8 | Per-core byte enables |
| stData | input | 2 x DATA_W | Per-core store data |
| stReady | output | 2 | Store accepted this cycle when high |
| fence | input | 2 | Per-core fence request |
| stall | output | 2 | Core held by its fence |
| lkAddr | input | 2 x ADDR_W | Per-core lookup address |
| lkState | output | 2 x 2 | Line state at lookup address |
| lkData | output | 2 x DATA_W | Line data at lookup index |
| memAddr | output | ADDR_W | Memory word address |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | DATA_W | Memory write data |
| memRdData | input | DATA_W | Memory read data for memAddr, same cycle |

## Verification
The stimulus covers several cases:
- A store to an unheld line, which shows the queue hiding data and the ownership fill from memory.
- A follow-up store to the now-owned line, which must change nothing in memory.
- A peer store to a line the first core holds dirty, which exercises the writeback-and-forward path.
- Stores from both cores to one line in the same cycle. Here the intermediate cycle shows who won, and the final merge shows that neither write was lost.
- A conflicting-tag store, which forces a victim writeback.
- A burst to one byte with a fence behind it, which shows program order and the fence hold.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_E = 2'd2,
    LS_M = 2'd3
  } lineState_e;

  typedef enum logic {
    BUS_RFO = 1'b0,
    BUS_WB  = 1'b1
  } busKind_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic localWrite;
    logic fillWrite;
    logic victimClear;
  } sbufStrobe_t;
endpackage

// File: rtl/sbufDatapath.sv
module sbufDatapath
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbufStrobe_t         strobe,
  input  logic [ADDR_W-1:0]   stAddr,
  input  logic [DATA_W/8-1:0] stBe,
  input  logic [DATA_W-1:0]   stData,
  output logic                headValid,
  output logic                full,
  output logic                headOwned,
  output logic                victimDirty,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busData,
  input  logic [DATA_W-1:0]   fillData,
  input  logic                snoopRfo,
  input  logic [ADDR_W-1:0]   snoopAddr,
  output logic                snoopHitM,
  output logic [DATA_W-1:0]   snoopData,
  input  logic [ADDR_W-1:0]   lkAddr,
  output logic [1:0]          lkState,
  output logic [DATA_W-1:0]   lkData
);
  localparam int SETS  = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int BE_W  = DATA_W / 8;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // store queue
  logic [ADDR_W-1:0] qAddr [DEPTH];
  logic [BE_W-1:0]   qBe   [DEPTH];
  logic [DATA_W-1:0] qData [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;

  // line-state array
  lineState_e        lineSt   [SETS];
  logic [TAG_W-1:0]  lineTag  [SETS];
  logic [DATA_W-1:0] lineData [SETS];

  logic [ADDR_W-1:0]  headAddr;
  logic [INDEX_W-1:0] headIdx, snoopIdx, lkIdx;
  logic [TAG_W-1:0]   headTag, snoopTag, lkTag;
  logic               headTagHit, snoopHit;

  function automatic logic [DATA_W-1:0] mergeBytes(
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] nData,
    input logic [BE_W-1:0]   be
  );
    logic [DATA_W-1:0] res;
    res = base;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) res[8*b +: 8] = nData[8*b +: 8];
    end
    return res;
  endfunction

  assign headValid  = (count != '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign headAddr   = qAddr[rdPtr];
  assign headIdx    = headAddr[INDEX_W-1:0];
  assign headTag    = headAddr[ADDR_W-1:INDEX_W];
  assign headTagHit = (lineTag[headIdx] == headTag);
  assign headOwned  = headTagHit &&
                      (lineSt[headIdx] == LS_M || lineSt[headIdx] == LS_E);
  assign victimDirty = !headTagHit && (lineSt[headIdx] == LS_M);
  assign busAddr    = victimDirty ? {lineTag[headIdx], headIdx} : headAddr;
  assign busData    = lineData[headIdx];

  assign snoopIdx  = snoopAddr[INDEX_W-1:0];
  assign snoopTag  = snoopAddr[ADDR_W-1:INDEX_W];
  assign snoopHit  = (lineSt[snoopIdx] != LS_I) && (lineTag[snoopIdx] == snoopTag);
  assign snoopHitM = snoopHit && (lineSt[snoopIdx] == LS_M);
  assign snoopData = lineData[snoopIdx];

  assign lkIdx   = lkAddr[INDEX_W-1:0];
  assign lkTag   = lkAddr[ADDR_W-1:INDEX_W];
  assign lkState = (lineTag[lkIdx] == lkTag) ? lineSt[lkIdx] : LS_I;
  assign lkData  = lineData[lkIdx];

  // queue pointers and storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) begin
        qAddr[wrPtr] <= stAddr;
        qBe[wrPtr]   <= stBe;
        qData[wrPtr] <= stData;
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (strobe.pop) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
    end
  end

  // line array: snoop has priority over own drain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        lineSt[s]   <= LS_I;
        lineTag[s]  <= '0;
        lineData[s] <= '0;
      end
    end else if (snoopRfo && snoopHit) begin
      lineSt[snoopIdx] <= LS_I;
    end else if (strobe.localWrite) begin
      lineData[headIdx] <= mergeBytes(lineData[headIdx], qData[rdPtr], qBe[rdPtr]);
      lineSt[headIdx]   <= LS_M;
    end else if (strobe.fillWrite) begin
      lineData[headIdx] <= mergeBytes(fillData, qData[rdPtr], qBe[rdPtr]);
      lineTag[headIdx]  <= headTag;
      lineSt[headIdx]   <= LS_M;
    end else if (strobe.victimClear) begin
      lineSt[headIdx] <= LS_I;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R8

  AST_UNOWNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.localWrite |-> headOwned); // R2

  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (snoopRfo && snoopHit) |=> lineSt[$past(snoopIdx)] == LS_I); // R3
endmodule

// File: rtl/sbufControl.sv
module sbufControl
  import sbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stValid,
  input  logic        fence,
  input  logic        headValid,
  input  logic        full,
  input  logic        headOwned,
  input  logic        victimDirty,
  input  logic        grant,
  input  logic        snoopRfo,
  output sbufStrobe_t strobe,
  output logic        stReady,
  output logic        stall,
  output logic        busReq,
  output busKind_e    busKind
);
  assign stall   = fence && headValid;
  assign stReady = !full && !stall;
  assign busReq  = headValid && !headOwned;
  assign busKind = victimDirty ? BUS_WB : BUS_RFO;

  always_comb begin
    strobe             = '0;
    strobe.push        = stValid && stReady;
    strobe.localWrite  = headValid && headOwned && !snoopRfo;
    strobe.fillWrite   = grant && (busKind == BUS_RFO);
    strobe.victimClear = grant && (busKind == BUS_WB);
    strobe.pop         = strobe.localWrite || strobe.fillWrite;
  end

  AST_FENCE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (fence && headValid) |-> !strobe.push); // R6

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> busReq); // R7
endmodule

// File: rtl/coherentStoreSys.sv
module coherentStoreSys
  import sbuf_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int INDEX_W = 2,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               stValid,
  input  logic [1:0][ADDR_W-1:0]   stAddr,
  input  logic [1:0][DATA_W/8-1:0] stBe,
  input  logic [1:0][DATA_W-1:0]   stData,
  output logic [1:0]               stReady,
  input  logic [1:0]               fence,
  output logic [1:0]               stall,
  input  logic [1:0][ADDR_W-1:0]   lkAddr,
  output logic [1:0][1:0]          lkState,
  output logic [1:0][DATA_W-1:0]   lkData,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memWrEn,
  output logic [DATA_W-1:0]        memWrData,
  input  logic [DATA_W-1:0]        memRdData
);
  localparam int NCORE = 2;

  sbufStrobe_t       strobe    [NCORE];
  logic [1:0]        busReq, grant, snoopRfo, snoopHitM;
  busKind_e          busKind   [NCORE];
  logic [ADDR_W-1:0] busAddr   [NCORE];
  logic [DATA_W-1:0] busData   [NCORE];
  logic [DATA_W-1:0] snoopData [NCORE];
  logic [DATA_W-1:0] fillData  [NCORE];
  logic [1:0]        headValid, full, headOwned, victimDirty;
  logic              winner;

  // fixed-priority arbiter: core 0 first
  assign grant[0] = busReq[0];
  assign grant[1] = busReq[1] && !busReq[0];
  assign winner   = grant[1];

  for (genvar c = 0; c < NCORE; c++) begin : gCore
    localparam int PEER = NCORE - 1 - c;

    assign snoopRfo[c] = grant[PEER] && (busKind[PEER] == BUS_RFO);
    assign fillData[c] = snoopHitM[PEER] ? snoopData[PEER] : memRdData;

    sbufControl uCtl (
      .clk(clk), .rstN(rstN),
      .stValid(stValid[c]), .fence(fence[c]),
      .headValid(headValid[c]), .full(full[c]),
      .headOwned(headOwned[c]), .victimDirty(victimDirty[c]),
      .grant(grant[c]), .snoopRfo(snoopRfo[c]),
      .strobe(strobe[c]), .stReady(stReady[c]), .stall(stall[c]),
      .busReq(busReq[c]), .busKind(busKind[c])
    );

    sbufDatapath #(
      .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
    ) uDp (
      .clk(clk), .rstN(rstN), .strobe(strobe[c]),
      .stAddr(stAddr[c]), .stBe(stBe[c]), .stData(stData[c]),
      .headValid(headValid[c]), .full(full[c]),
      .headOwned(headOwned[c]), .victimDirty(victimDirty[c]),
      .busAddr(busAddr[c]), .busData(busData[c]), .fillData(fillData[c]),
      .snoopRfo(snoopRfo[c]), .snoopAddr(busAddr[PEER]),
      .snoopHitM(snoopHitM[c]), .snoopData(snoopData[c]),
      .lkAddr(lkAddr[c]), .lkState(lkState[c]), .lkData(lkData[c])
    );
  end

  // shared memory port
  always_comb begin
    memAddr   = busAddr[winner];
    memWrEn   = 1'b0;
    memWrData = busData[winner];
    if (|grant) begin
      if (busKind[winner] == BUS_WB) begin
        memWrEn = 1'b1;
      end else if (snoopHitM[!winner]) begin
        memWrEn   = 1'b1;
        memWrData = snoopData[!winner];
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R7

  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq == 2'b11) |-> grant == 2'b01); // R7

  AST_DIRTY_WB0: assert property (@(posedge clk) disable iff (!rstN)
    (snoopRfo[0] && snoopHitM[0]) |-> (memWrEn && memWrData == snoopData[0])); // R4

  AST_DIRTY_WB1: assert property (@(posedge clk) disable iff (!rstN)
    (snoopRfo[1] && snoopHitM[1]) |-> (memWrEn && memWrData == snoopData[1])); // R4

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (lkAddr[0] == lkAddr[1] && lkState[0][1]) |-> !lkState[1][1]); // R11
endmodule

// File: tb/coherentStoreSys_test.sv
module coherentStoreSys_test;
  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       stValid = '0;
  logic [1:0][5:0]  stAddr = '0;
  logic [1:0][3:0]  stBe = '0;
  logic [1:0][31:0] stData = '0;
  logic [1:0]       stReady;
  logic [1:0]       fence = '0;
  logic [1:0]       stall;
  logic [1:0][5:0]  lkAddr = '0;
  logic [1:0][1:0]  lkState;
  logic [1:0][31:0] lkData;
  logic [5:0]       memAddr;
  logic             memWrEn;
  logic [31:0]      memWrData;
  logic [31:0]      memRdData;
  logic [31:0]      mem [64];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    int          core;
    logic [5:0]  addr;
    logic [1:0]  st;
    logic [31:0] data;
    bit          useData;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  coherentStoreSys uut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stBe(stBe),
    .stData(stData), .stReady(stReady), .fence(fence), .stall(stall),
    .lkAddr(lkAddr), .lkState(lkState), .lkData(lkData), .memAddr(memAddr),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdData(memRdData)
  );

  assign memRdData = mem[memAddr];
  always_ff @(posedge clk) if (memWrEn) mem[memAddr] <= memWrData;

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expectLine(string req, int core, logic [5:0] addr,
                            logic [1:0] st, logic [31:0] data, bit useData);
    expItem_t it;
    it.req = req; it.core = core; it.addr = addr;
    it.st = st; it.data = data; it.useData = useData;
    expQ.push_back(it);
  endtask

  // monitor side: pops and compares against the lookup ports
  task automatic monitor();
    while (expQ.size() > 0) begin
      expItem_t it = expQ.pop_front();
      lkAddr[it.core] = it.addr;
      #1;
      checkVal({it.req, " state"}, 32'(lkState[it.core]), 32'(it.st));
      if (it.useData) checkVal({it.req, " data"}, lkData[it.core], it.data);
    end
  endtask

  // called at a negedge; accepted on the next posedge
  task automatic store(int c, logic [5:0] a, logic [3:0] be, logic [31:0] d);
    stValid[c] = 1'b1; stAddr[c] = a; stBe[c] = be; stData[c] = d;
    @(negedge clk);
    stValid[c] = 1'b0;
  endtask

  task automatic storeBoth(logic [5:0] a, logic [3:0] be0, logic [31:0] d0,
                           logic [3:0] be1, logic [31:0] d1);
    stValid = 2'b11; stAddr[0] = a; stAddr[1] = a;
    stBe[0] = be0; stData[0] = d0; stBe[1] = be1; stData[1] = d1;
    @(negedge clk);
    stValid = 2'b00;
  endtask

  task automatic fenceWait(int c);
    int guard = 0;
    fence[c] = 1'b1;
    #1;
    while (stall[c] && guard < 100) begin
      @(negedge clk); #1; guard++;
    end
    checkVal("R6 stall released after drain", 32'(stall[c]), 32'd0);
    fence[c] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 | i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    checkVal("R10 stReady", 32'(stReady), 32'd3);
    checkVal("R10 stall", 32'(stall), 32'd0);
    expectLine("R10 core0 line", 0, 6'd5, 2'd0, '0, 0);
    expectLine("R10 core1 line", 1, 6'd10, 2'd0, '0, 0);
    monitor();

    // R1/R2: store to unheld line, hidden until drained, then owned
    @(negedge clk);
    store(0, 6'd5, 4'b0011, 32'h0000_1234);
    expectLine("R1 buffered store hidden", 0, 6'd5, 2'd0, '0, 0);
    monitor();
    fenceWait(0);
    expectLine("R2 fill merged Modified", 0, 6'd5, 2'd3, 32'h5A00_1234, 1);
    expectLine("R11 peer not holding", 1, 6'd5, 2'd0, '0, 0);
    monitor();

    // R5: hit on Modified line, memory untouched
    @(negedge clk);
    store(0, 6'd5, 4'b1100, 32'hABCD_0000);
    fenceWait(0);
    expectLine("R5 owned hit write", 0, 6'd5, 2'd3, 32'hABCD_1234, 1);
    monitor();
    checkVal("R5 memory not written", mem[5], 32'h5A00_0005);

    // R3/R4: peer takes a dirty line
    @(negedge clk);
    store(1, 6'd5, 4'b0001, 32'h0000_0077);
    fenceWait(1);
    expectLine("R4 requester merged peer data", 1, 6'd5, 2'd3, 32'hABCD_1277, 1);
    expectLine("R3 peer invalidated", 0, 6'd5, 2'd0, '0, 0);
    monitor();
    checkVal("R4 dirty writeback to memory", mem[5], 32'hABCD_1234);

    // R7: both cores, same line, same cycle
    @(negedge clk);
    storeBoth(6'd10, 4'b0001, 32'h0000_0011, 4'b0010, 32'h0000_2200);
    @(negedge clk);
    expectLine("R7 core0 wins first", 0, 6'd10, 2'd3, 32'h5A00_0011, 1);
    expectLine("R7 core1 waits", 1, 6'd10, 2'd0, '0, 0);
    monitor();
    @(negedge clk);
    fenceWait(0);
    fenceWait(1);
    expectLine("R7 both writes kept", 1, 6'd10, 2'd3, 32'h5A00_2211, 1);
    expectLine("R7 first owner invalid", 0, 6'd10, 2'd0, '0, 0);
    monitor();
    checkVal("R7 first write reached memory", mem[10], 32'h5A00_0011);

    // R9: victim writeback on conflicting tag
    @(negedge clk);
    store(0, 6'd1, 4'b1111, 32'h1111_1111);
    store(0, 6'd9, 4'b0001, 32'h0000_0099);
    fenceWait(0);
    checkVal("R9 victim written back", mem[1], 32'h1111_1111);
    expectLine("R9 victim invalid", 0, 6'd1, 2'd0, '0, 0);
    expectLine("R9 new line owned", 0, 6'd9, 2'd3, 32'h5A00_0099, 1);
    monitor();

    // R8/R6: back-to-back stores in order, fence holds while not empty
    @(negedge clk);
    store(0, 6'd2, 4'b0001, 32'h0000_0001);
    store(0, 6'd2, 4'b0010, 32'h0000_BB00);
    store(0, 6'd2, 4'b0001, 32'h0000_0003);
    store(0, 6'd2, 4'b0001, 32'h0000_0004);
    fence[0] = 1'b1;
    #1;
    checkVal("R6 stall while queue busy", 32'(stall[0]), 32'd1);
    checkVal("R6 stReady low under fence", 32'(stReady[0]), 32'd0);
    fenceWait(0);
    expectLine("R8 program order drain", 0, 6'd2, 2'd3, 32'h5A00_BB04, 1);
    monitor();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule